// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps the time of day for a precision timing subsystem. It holds a 48-bit seconds count and a 30-bit nanoseconds count. On every clock the nanoseconds advance by a fixed nominal step. When they reach one billion they wrap and carry into the seconds. The live time goes out on two output buses so that timestamping logic elsewhere on the chip can sample it. A frequency adjuster can stretch or shrink any single step by one nanosecond.

Software reaches the counter through four 32-bit registers. A command register holds a 3-bit action field. Three data registers hold the upper seconds, the lower seconds and the nanoseconds.

The data registers serve two purposes:
- They stage the values that a load or an offset uses.
- They receive a snapshot of the live time.

A snapshot captures seconds and nanoseconds in the same cycle, so they stay consistent however long the register reads take.

Commands are run by a small state machine with four states:
- `ST_IDLE` is the rest state.
- `ST_LOAD`, `ST_SAVE` and `ST_DELTA` each last one cycle.

Transitions:
- A command-register write whose action field is load (1), save (2) or delta (4) moves the machine from any state to the matching action state.
- Any other write, or no write, sends it to `ST_IDLE`.

The machine therefore always returns to idle in the cycle after an action state, unless a new command arrives.

Top module: `ptp_tod_clock`

## Requirements
- R1: While reset is held, the live seconds and nanoseconds are zero and all four registers read zero.
- R2: Without a command or a correction, the live nanoseconds grow by exactly NS_STEP (default 8) per clock and the seconds hold.
- R3: Nanoseconds stay below 1,000,000,000. When a step reaches or passes that value, the remainder is kept and the 48-bit seconds count goes up by one, including the carry from the low 32 bits into the upper 16.
- R4: While `corr_valid` is high, that clock's step is NS_STEP+1 when `corr_dir` is 1 and NS_STEP-1 when `corr_dir` is 0.
- R5: Writing action code 1 into bits [5:3] of the command register (offset 0x00) makes the live time equal to the staged value at the next clock. The staged value is seconds[47:32] from offset 0x04 bits [15:0], seconds[31:0] from offset 0x08, and nanoseconds from offset 0x0C bits [29:0].
- R6: Writing action code 2 copies the live time of the clock at which the command executes into offsets 0x04, 0x08 and 0x0C. The snapshot nanoseconds read as a zero-extended 30-bit value.
- R7: Writing action code 4 treats the full 32-bit value at offset 0x0C as a signed nanosecond offset. At the next clock the time advances by NS_STEP plus that offset, borrowing from or carrying into the seconds so that the nanoseconds stay in range.
- R8: A delta offset whose magnitude is 500,000,000 or more is ignored: the time only makes its normal step.
- R9: Action codes 0, 3, 5, 6 and 7 neither change the time nor touch the data registers.
- R10: The command register reads the current action code in bits [5:3]. It shows the code during the one executing cycle and 0 from then on. Bit 0 (domain) and bit 2 (sync) keep the written values when the code written does not act, and clear when code 1, 2 or 4 is written.
- R11: Offset 0x04 stores only 16 bits; bits [31:16] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset for reads and writes |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data for `reg_addr` (combinational) |
| corr_valid | input | 1 | Apply a one-nanosecond correction on this step |
| corr_dir | input | 1 | Correction direction: 1 adds, 0 removes |
| tod_sec | output | SEC_W (48) | Live seconds |
| tod_ns | output | NS_W (30) | Live nanoseconds |

## Verification
The bench loads times that sit a few nanoseconds before a second boundary, and one where the low 32 seconds bits are all ones. A counter that compares against the wrong limit, or that drops the carry into the upper seconds, would show a nanosecond value of one billion or more, or the wrong seconds.

It applies negative and positive offsets that cross a second, and offsets of exactly plus and minus half a second. A design with a wrong sign extension or a missing borrow would land far from the expected time. An inclusive range check would accept the half-second offsets.

It snapshots a running clock and compares the readback with the live value observed just before execution, which exposes a one-cycle skew. It also checks that the inert codes change neither the time nor the staged nanoseconds.

// File: rtl/tod_pkg.sv
package tod_pkg;

    // Action codes carried in bits [5:3] of the command register
    localparam logic [2:0] CODE_IDLE  = 3'd0;
    localparam logic [2:0] CODE_LOAD  = 3'd1;
    localparam logic [2:0] CODE_SAVE  = 3'd2;
    localparam logic [2:0] CODE_DELTA = 3'd4;

    // Byte offsets of the register bank
    localparam logic [7:0] OFS_CMD    = 8'h00;
    localparam logic [7:0] OFS_SEC_HI = 8'h04;
    localparam logic [7:0] OFS_SEC_LO = 8'h08;
    localparam logic [7:0] OFS_NSEC   = 8'h0C;

    // Bit positions inside the command register
    localparam int CODE_LSB = 3;
    localparam int DOM_BIT  = 0;
    localparam int SYNC_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SAVE,
        ST_DELTA
    } tod_state_e;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [2:0] cmd_code,
    input  logic       cmd_dom,
    input  logic       cmd_sync,
    output logic       do_load,
    output logic       do_save,
    output logic       do_delta,
    output logic [2:0] code_rd,
    output logic       dom_q,
    output logic       sync_q
);

    tod_state_e state, nxt;
    logic       acting;

    always_comb begin
        acting = (cmd_code == CODE_LOAD) || (cmd_code == CODE_SAVE) ||
                 (cmd_code == CODE_DELTA);
    end

    // Next-state logic: any acting command is taken from every state
    always_comb begin
        nxt = ST_IDLE;
        if (cmd_wr) begin
            unique case (cmd_code)
                CODE_LOAD:  nxt = ST_LOAD;
                CODE_SAVE:  nxt = ST_SAVE;
                CODE_DELTA: nxt = ST_DELTA;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Domain and sync flags: stored on inert writes, cleared by actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_q  <= 1'b0;
            sync_q <= 1'b0;
        end else if (cmd_wr) begin
            dom_q  <= acting ? 1'b0 : cmd_dom;
            sync_q <= acting ? 1'b0 : cmd_sync;
        end
    end

    // Output decode
    always_comb begin
        do_load  = 1'b0;
        do_save  = 1'b0;
        do_delta = 1'b0;
        code_rd  = CODE_IDLE;
        unique case (state)
            ST_IDLE:  ;
            ST_LOAD:  begin do_load  = 1'b1; code_rd = CODE_LOAD;  end
            ST_SAVE:  begin do_save  = 1'b1; code_rd = CODE_SAVE;  end
            ST_DELTA: begin do_delta = 1'b1; code_rd = CODE_DELTA; end
        endcase
    end

    // R10
    action_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd != CODE_IDLE && !cmd_wr) |=> (code_rd == CODE_IDLE));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CODE_LOAD) |=> (!dom_q && !sync_q && do_load));

endmodule

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              do_save,
    input  logic [SEC_W-1:0]  live_sec,
    input  logic [NS_W-1:0]   live_ns,
    input  logic [2:0]        code_rd,
    input  logic              dom_q,
    input  logic              sync_q,
    output logic [DATA_W-1:0] rdata,
    output logic [SEC_W-1:0]  stg_sec,
    output logic [DATA_W-1:0] stg_ns
);

    localparam int LO_W = DATA_W;
    localparam int HI_W = SEC_W - LO_W;

    logic [HI_W-1:0]   sec_hi;
    logic [LO_W-1:0]   sec_lo;
    logic [DATA_W-1:0] ns_q;

    // A snapshot wins over a register write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_hi <= '0;
            sec_lo <= '0;
            ns_q   <= '0;
        end else if (do_save) begin
            sec_hi <= live_sec[SEC_W-1:LO_W];
            sec_lo <= live_sec[LO_W-1:0];
            ns_q   <= DATA_W'(live_ns);
        end else if (wr) begin
            if (addr == ADDR_W'(OFS_SEC_HI)) sec_hi <= wdata[HI_W-1:0];
            if (addr == ADDR_W'(OFS_SEC_LO)) sec_lo <= wdata;
            if (addr == ADDR_W'(OFS_NSEC))   ns_q   <= wdata;
        end
    end

    always_comb begin
        stg_sec = {sec_hi, sec_lo};
        stg_ns  = ns_q;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CMD)) begin
            rdata[CODE_LSB +: 3] = code_rd;
            rdata[SYNC_BIT]      = sync_q;
            rdata[DOM_BIT]       = dom_q;
        end else if (addr == ADDR_W'(OFS_SEC_HI)) begin
            rdata = DATA_W'(sec_hi);
        end else if (addr == ADDR_W'(OFS_SEC_LO)) begin
            rdata = sec_lo;
        end else if (addr == ADDR_W'(OFS_NSEC)) begin
            rdata = ns_q;
        end
    end

    // R6
    snapshot_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_save |=> (ns_q == DATA_W'($past(live_ns)) &&
                     {sec_hi, sec_lo} == $past(live_sec)));

endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int SEC_W      = 48,
    parameter int NS_W       = 30,
    parameter int DATA_W     = 32,
    parameter int NS_PER_SEC = 1000000000,
    parameter int NS_STEP    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     do_load,
    input  logic                     do_delta,
    input  logic [SEC_W-1:0]         ld_sec,
    input  logic [DATA_W-1:0]        ld_word,
    input  logic                     corr_valid,
    input  logic                     corr_dir,
    output logic [SEC_W-1:0]         sec_q,
    output logic [NS_W-1:0]          ns_q
);

    localparam int SUM_W = DATA_W + 2;
    localparam logic signed [SUM_W-1:0] SEC_NS  = SUM_W'(NS_PER_SEC);
    localparam logic signed [SUM_W-1:0] HALF_NS = SUM_W'(NS_PER_SEC / 2);
    localparam logic signed [SUM_W-1:0] STEP    = SUM_W'(NS_STEP);

    logic signed [SUM_W-1:0] ns_ext, off_ext, corr_ext, sum;
    logic                    off_ok;
    logic [SEC_W-1:0]        sec_n;
    logic [NS_W-1:0]         ns_n;

    always_comb begin
        ns_ext   = $signed({{(SUM_W-NS_W){1'b0}}, ns_q});
        off_ext  = $signed({{2{ld_word[DATA_W-1]}}, ld_word});
        off_ok   = (off_ext > -HALF_NS) && (off_ext < HALF_NS);
        corr_ext = corr_valid ? (corr_dir ? SUM_W'(1) : {SUM_W{1'b1}}) : '0;
        sum      = ns_ext + STEP + corr_ext + ((do_delta && off_ok) ? off_ext : '0);
        if (sum < 0) begin
            ns_n  = NS_W'(sum + SEC_NS);
            sec_n = sec_q - SEC_W'(1);
        end else if (sum >= SEC_NS) begin
            ns_n  = NS_W'(sum - SEC_NS);
            sec_n = sec_q + SEC_W'(1);
        end else begin
            ns_n  = NS_W'(sum);
            sec_n = sec_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else if (do_load) begin
            sec_q <= ld_sec;
            ns_q  <= ld_word[NS_W-1:0];
        end else begin
            sec_q <= sec_n;
            ns_q  <= ns_n;
        end
    end

    // R2
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_delta && !corr_valid && 32'(ns_q) < NS_PER_SEC - NS_STEP)
        |=> (32'(ns_q) == 32'($past(ns_q)) + NS_STEP && $stable(sec_q)));

    // R3
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_delta && !corr_valid &&
         32'(ns_q) >= NS_PER_SEC - NS_STEP && 32'(ns_q) < NS_PER_SEC)
        |=> (sec_q == $past(sec_q) + SEC_W'(1)));

    // R3
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && 32'(ns_q) < NS_PER_SEC) |=> (32'(ns_q) < NS_PER_SEC));

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (sec_q == $past(ld_sec) && ns_q == $past(ld_word[NS_W-1:0])));

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import tod_pkg::*;
#(
    parameter int SEC_W      = 48,
    parameter int NS_W       = 30,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int NS_PER_SEC = 1000000000,
    parameter int NS_STEP    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              corr_valid,
    input  logic              corr_dir,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);

    logic             cmd_wr;
    logic             do_load, do_save, do_delta;
    logic [2:0]       code_rd;
    logic             dom_q, sync_q;
    logic [SEC_W-1:0] stg_sec;
    logic [DATA_W-1:0] stg_ns;

    assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));

    tod_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_code (reg_wdata[CODE_LSB +: 3]),
        .cmd_dom  (reg_wdata[DOM_BIT]),
        .cmd_sync (reg_wdata[SYNC_BIT]),
        .do_load  (do_load),
        .do_save  (do_save),
        .do_delta (do_delta),
        .code_rd  (code_rd),
        .dom_q    (dom_q),
        .sync_q   (sync_q)
    );

    tod_regs #(
        .SEC_W (SEC_W), .NS_W (NS_W), .DATA_W (DATA_W), .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .do_save  (do_save),
        .live_sec (tod_sec),
        .live_ns  (tod_ns),
        .code_rd  (code_rd),
        .dom_q    (dom_q),
        .sync_q   (sync_q),
        .rdata    (reg_rdata),
        .stg_sec  (stg_sec),
        .stg_ns   (stg_ns)
    );

    tod_counter #(
        .SEC_W (SEC_W), .NS_W (NS_W), .DATA_W (DATA_W),
        .NS_PER_SEC (NS_PER_SEC), .NS_STEP (NS_STEP)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_load    (do_load),
        .do_delta   (do_delta),
        .ld_sec     (stg_sec),
        .ld_word    (stg_ns),
        .corr_valid (corr_valid),
        .corr_dir   (corr_dir),
        .sec_q      (tod_sec),
        .ns_q       (tod_ns)
    );

endmodule

// File: tb/ptp_tod_clock_test.sv
module ptp_tod_clock_test;

    localparam int     CLK_PERIOD = 10;
    localparam longint NSPS       = 1000000000;
    localparam longint STEP       = 8;
    localparam logic [7:0] A_CMD = 8'h00, A_HI = 8'h04, A_LO = 8'h08, A_NS = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        corr_valid, corr_dir;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    typedef struct {
        string       req;
        int          sel;
        logic [63:0] exp;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    ptp_tod_clock uut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .corr_valid (corr_valid),
        .corr_dir (corr_dir), .tod_sec (tod_sec), .tod_ns (tod_ns)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin : mon
            exp_t        it;
            logic [63:0] act;
            wait (q.size() > 0);
            it = q.pop_front();
            case (it.sel)
                0:       act = 64'(tod_sec);
                1:       act = 64'(tod_ns);
                default: act = 64'(reg_rdata);
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(input string req, input int sel, input logic [63:0] e);
        exp_t it;
        it.req = req; it.sel = sel; it.exp = e;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] a, input logic [31:0] e);
        reg_addr = a;
        #1;
        push(req, 2, 64'(e));
    endtask

    task automatic live_expect(input string req, input longint s, input longint n);
        push(req, 0, s);
        push(req, 1, n);
    endtask

    task automatic grab(output longint s, output longint n);
        s = longint'(tod_sec);
        n = longint'(tod_ns);
    endtask

    function automatic void add_ns(inout longint s, inout longint n, input longint d);
        n = n + d;
        while (n < 0)     begin n = n + NSPS; s = s - 1; end
        while (n >= NSPS) begin n = n - NSPS; s = s + 1; end
    endfunction

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] ns);
        wr(A_CMD, 32'h0);
        wr(A_HI, hi);
        wr(A_LO, lo);
        wr(A_NS, ns);
        wr(A_CMD, 32'd1 << 3);
    endtask

    task automatic delta_step(input string req, input logic [31:0] off, input longint applied);
        longint s, n;
        wr(A_NS, off);
        wr(A_CMD, 32'd4 << 3);
        grab(s, n);
        @(negedge clk);
        add_ns(s, n, STEP + applied);
        live_expect(req, s, n);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        longint s, n;
        logic [2:0] inert [5] = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
        corr_valid = 1'b0; corr_dir = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        live_expect("R1", 0, 0);
        rd_expect("R1", A_CMD, 32'h0);
        rd_expect("R1", A_HI, 32'h0);
        rd_expect("R1", A_LO, 32'h0);
        rd_expect("R1", A_NS, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: free-running step
        grab(s, n);
        @(negedge clk);
        live_expect("R2", s, n + STEP);
        repeat (5) @(negedge clk);
        live_expect("R2", s, n + 6 * STEP);

        // R5 then R3: load just below a second, then wrap
        load_time(32'h0, 32'd5, 32'd999999996);
        @(negedge clk);
        live_expect("R5", 5, 999999996);
        @(negedge clk);
        live_expect("R3", 6, 4);

        // R11: upper seconds register keeps 16 bits
        wr(A_HI, 32'hABCD_0012);
        rd_expect("R11", A_HI, 32'h0000_0012);

        // R3: carry from low seconds into upper seconds
        load_time(32'h0000_0012, 32'hFFFF_FFFF, 32'd999999992);
        @(negedge clk);
        live_expect("R5", 48'h0012_FFFF_FFFF, 999999992);
        @(negedge clk);
        live_expect("R3", 48'h0013_0000_0000, 0);

        // R4: corrections
        grab(s, n);
        corr_valid = 1'b1; corr_dir = 1'b1;
        @(negedge clk);
        corr_valid = 1'b0;
        live_expect("R4", s, n + STEP + 1);
        grab(s, n);
        corr_valid = 1'b1; corr_dir = 1'b0;
        @(negedge clk);
        corr_valid = 1'b0;
        live_expect("R4", s, n + STEP - 1);

        // R6: snapshot of the running clock
        wr(A_CMD, 32'd2 << 3);
        grab(s, n);
        @(negedge clk);
        rd_expect("R6", A_HI, 32'(s[47:32]));
        rd_expect("R6", A_LO, s[31:0]);
        rd_expect("R6", A_NS, 32'(n));

        // R10: command register readback and flag handling
        wr(A_CMD, 32'h5);
        rd_expect("R10", A_CMD, 32'h5);
        wr(A_CMD, 32'h15);
        rd_expect("R10", A_CMD, 32'h10);
        @(negedge clk);
        rd_expect("R10", A_CMD, 32'h0);

        // R9: inert codes leave time and registers alone
        wr(A_NS, 32'h1234_5678);
        foreach (inert[i]) begin
            wr(A_CMD, 32'(inert[i]) << 3);
            grab(s, n);
            @(negedge clk);
            add_ns(s, n, STEP);
            live_expect("R9", s, n);
            rd_expect("R9", A_NS, 32'h1234_5678);
        end

        // R7: offsets crossing a second in both directions
        load_time(32'h0, 32'd10, 32'd100);
        delta_step("R7", -32'sd1000, -1000);
        delta_step("R7", 32'd499999999, 499999999);
        delta_step("R7", 32'd700000000 - 32'd700000000 + 32'd300, 300);

        // R8: half-second offsets are rejected
        delta_step("R8", 32'd500000000, 0);
        delta_step("R8", -32'sd500000000, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule